// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block is the control engine of a single DMA channel. It decides when the channel runs, pauses or stops. It keeps the current source and destination descriptor pointers and works out where the next source descriptor lives. Software drives three control bits through a one-cycle write strobe: enable, continue, and continue-from-start. The sequencer then fetches descriptors through a simple request/acknowledge port. For each source descriptor it hands one transfer to the payload datapath and waits for a completion strobe. The command, chaining type and interrupt flag of that descriptor then decide what happens next.

Descriptors are 16 bytes in size and must be aligned to 16 bytes. A descriptor is either linear, where its successor follows it directly, or linked, where its successor's address is stored in the word just after it. A descriptor can end the chain, or it can halt the channel so that software can resume it later. Software resumes either from the next descriptor or from the programmed start addresses. In register-pointer mode the descriptor fields come from input pins and are never fetched. Event pulses feed the interrupt logic.

Top module: `dcs_top`

## Requirements
- R1: After reset the status reads 0 (disabled), the enable and continue bits read 0, and no fetch request, transfer request or event is active.
- R2: A write with enable=1 while disabled loads both pointers from the start inputs and makes the status read 1 (enabled). In memory mode it first fetches the destination descriptor (fetch kind 1) at the destination start address, then the source descriptor (fetch kind 0) at the source start address.
- R3: A linear descriptor (chaining flag 0) is followed by the descriptor 16 bytes further on, with the address wrapping modulo 2^49.
- R4: A linked descriptor (chaining flag 1) is followed by the descriptor whose address is returned by a pointer fetch (fetch kind 2) at its own address plus 16.
- R5: When a transfer completes, the 2-bit command field acts as follows. Command 2 clears the enable bit and sets the status to 0. Command 1 sets the status to 2 (paused), raises the pause pulse and leaves enable at 1. Commands 0 and 3 move on to the next descriptor.
- R6: Every transfer completion raises the done pulse. The source-done pulse is raised in that same cycle only when the descriptor's interrupt flag is 1.
- R7: A write of enable=1 and continue=1 while paused, with continue-from-start=0, steps the source pointer past the halted descriptor according to that descriptor's chaining flag. The same write returns continue to 0 and makes the status read 1.
- R8: A write of enable=1 and continue=1 while paused, with continue-from-start=1, reloads both pointers from the start inputs and fetches the destination descriptor again before the source descriptor.
- R9: While paused, a write of enable=0 with continue=1 sets the status to 0. A write of enable=1 with continue=0 leaves the channel paused and issues no fetch.
- R10: A source or destination descriptor address whose low four bits are not zero issues no fetch. It latches an error, pulses the matching read-error event and disables the channel, and the status then reads 3. The next write with enable=1 clears the error.
- R11: In register-pointer mode the descriptor comes from the register inputs, no fetch is issued, and one transfer is followed by status 0 with enable cleared.
- R12: A control write that arrives while a fetch or transfer is in progress, including the cycle in which the completion strobe arrives, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | One-cycle control write strobe |
| ctl_en | input | 1 | Written enable value |
| ctl_cont | input | 1 | Written continue value |
| ctl_from_start | input | 1 | Written continue-from-start value |
| reg_mode | input | 1 | 1: descriptor taken from register inputs |
| reg_op | input | 2 | Register descriptor command |
| reg_linked | input | 1 | Register descriptor chaining flag |
| reg_irq | input | 1 | Register descriptor interrupt flag |
| src_start | input | 49 | Source descriptor start address |
| dst_start | input | 49 | Destination descriptor start address |
| fetch_req | output | 1 | Fetch request, held until acknowledged |
| fetch_kind | output | 2 | 0 source descriptor, 1 destination descriptor, 2 link pointer |
| fetch_addr | output | 49 | Fetch byte address |
| fetch_ack | input | 1 | One-cycle fetch response strobe |
| rsp_op | input | 2 | Fetched command field |
| rsp_linked | input | 1 | Fetched chaining flag |
| rsp_irq | input | 1 | Fetched interrupt flag |
| rsp_link | input | 49 | Low 49 bits of a fetched link pointer |
| xfer_go | output | 1 | Transfer requested from the datapath |
| xfer_done | input | 1 | One-cycle transfer completion strobe |
| ch_status | output | 2 | 0 disabled, 1 enabled, 2 paused, 3 error |
| en_bit | output | 1 | Current enable bit |
| cont_bit | output | 1 | Current continue bit |
| src_ptr | output | 49 | Current source descriptor pointer |
| dst_ptr | output | 49 | Current destination descriptor pointer |
| ev_xfer_done | output | 1 | Transfer-done event pulse |
| ev_src_done | output | 1 | Source-descriptor-done event pulse |
| ev_pause | output | 1 | Pause event pulse |
| ev_src_rd_err | output | 1 | Source descriptor read error pulse |
| ev_dst_rd_err | output | 1 | Destination descriptor read error pulse |

## Verification
A transfer completion and a software control write can land in the same cycle. The bench provokes this by raising the control strobe, carrying enable=0 and continue=1, in the exact cycle its datapath model returns the completion for a halting descriptor. The run is judged correct only if the channel ends up paused with enable still 1 and continue still 0, with the done, source-done and pause pulses all seen in one single cycle. A second case of coincidence is the pulse trio on its own: for a halting descriptor with its interrupt flag set, the three events must appear together rather than in successive cycles.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int ADDR_W     = 49;
    localparam int DESC_BYTES = 16;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int OP_W       = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2
    } ch_state_e;

    localparam logic [1:0] STATUS_FAULT = 2'd3;

    typedef enum logic [1:0] {
        FK_SRC  = 2'd0,
        FK_DST  = 2'd1,
        FK_LINK = 2'd2
    } fetch_kind_e;

    localparam logic [OP_W-1:0] OP_HALT = 2'd1;
    localparam logic [OP_W-1:0] OP_STOP = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DST,
        PH_SRC,
        PH_XFER,
        PH_LINK
    } phase_e;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic            linked;
        logic            irq;
    } desc_ctl_t;

    typedef struct packed {
        logic done;
        logic src_done;
        logic pause;
        logic src_err;
        logic dst_err;
    } ev_t;

    function automatic logic is_aligned(addr_t a);
        return a[DESC_SHIFT-1:0] == '0;
    endfunction

    function automatic addr_t next_linear(addr_t a);
        return a + addr_t'(DESC_BYTES);
    endfunction
endpackage

// File: rtl/dcs_ptr_unit.sv
module dcs_ptr_unit
    import dcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_start,
    input  logic  step_lin,
    input  logic  set_link,
    input  addr_t src_start,
    input  addr_t dst_start,
    input  addr_t link_val,
    output addr_t src_ptr,
    output addr_t dst_ptr
);
    addr_t src_q, dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load_start) begin
            src_q <= src_start;
            dst_q <= dst_start;
        end else if (step_lin) begin
            src_q <= next_linear(src_q);
        end else if (set_link) begin
            src_q <= link_val;
        end
    end

    assign src_ptr = src_q;
    assign dst_ptr = dst_q;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_start |=> (src_ptr == $past(src_start)) && (dst_ptr == $past(dst_start)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_lin && !load_start) |=> src_ptr == $past(src_ptr) + addr_t'(DESC_BYTES));

    // R4
    link_take_chk: assert property (@(posedge clk) disable iff (rst)
        (set_link && !load_start && !step_lin) |=> src_ptr == $past(link_val));
endmodule

// File: rtl/dcs_ctl_bits.sv
module dcs_ctl_bits
    import dcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       wr_en,
    input  logic       wr_cont,
    input  logic       clr_en,
    input  logic       clr_cont,
    input  logic       set_err,
    input  logic [1:0] state,
    output logic       en_q,
    output logic       cont_q,
    output logic       err_q,
    output logic [1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                en_q   <= wr_en;
                cont_q <= wr_cont && !clr_cont;
            end else if (clr_en) begin
                en_q   <= 1'b0;
            end
            if (set_err)
                err_q <= 1'b1;
            else if (accept && wr_en)
                err_q <= 1'b0;
        end
    end

    assign status = err_q ? STATUS_FAULT : state;

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && wr_en && !set_err) |=> !err_q);

    // R12
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clr_en) |=> en_q == $past(en_q));
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
    import dcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic        ctl_en,
    input  logic        ctl_cont,
    input  logic        ctl_from_start,
    input  logic        reg_mode,
    input  desc_ctl_t   reg_desc,
    input  addr_t       src_ptr,
    input  addr_t       dst_ptr,
    input  logic        fetch_ack,
    input  desc_ctl_t   rsp_desc,
    input  logic        xfer_done,
    output logic        accept,
    output logic        clr_en,
    output logic        clr_cont,
    output logic        set_err,
    output logic        load_start,
    output logic        step_lin,
    output logic        set_link,
    output logic [1:0]  state,
    output logic        fetch_req,
    output logic [1:0]  fetch_kind,
    output addr_t       fetch_addr,
    output logic        xfer_go,
    output ev_t         ev
);
    phase_e    phase_q, ph_n;
    ch_state_e state_q, st_n;
    desc_ctl_t cur_q, cur_n;
    ev_t       ev_q, ev_n;

    assign accept = ctl_wr && (phase_q == PH_IDLE);

    always_comb begin
        ph_n       = phase_q;
        st_n       = state_q;
        cur_n      = cur_q;
        ev_n       = '0;
        clr_en     = 1'b0;
        clr_cont   = 1'b0;
        set_err    = 1'b0;
        load_start = 1'b0;
        step_lin   = 1'b0;
        set_link   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (ctl_en) begin
                        if (state_q == CH_HOLD && ctl_cont) begin
                            clr_cont = 1'b1;
                            st_n     = CH_RUN;
                            if (ctl_from_start) begin
                                load_start = 1'b1;
                                if (reg_mode) begin
                                    cur_n = reg_desc;
                                    ph_n  = PH_XFER;
                                end else begin
                                    ph_n  = PH_DST;
                                end
                            end else if (cur_q.linked) begin
                                ph_n = PH_LINK;
                            end else begin
                                step_lin = 1'b1;
                                ph_n     = PH_SRC;
                            end
                        end else if (state_q == CH_OFF) begin
                            load_start = 1'b1;
                            st_n       = CH_RUN;
                            if (reg_mode) begin
                                cur_n = reg_desc;
                                ph_n  = PH_XFER;
                            end else begin
                                ph_n  = PH_DST;
                            end
                        end
                    end else if (state_q == CH_HOLD && ctl_cont) begin
                        st_n = CH_OFF;
                    end
                end
            end
            PH_DST: begin
                if (!is_aligned(dst_ptr)) begin
                    set_err     = 1'b1;
                    ev_n.dst_err = 1'b1;
                    st_n        = CH_OFF;
                    ph_n        = PH_IDLE;
                end else if (fetch_ack) begin
                    ph_n = PH_SRC;
                end
            end
            PH_SRC: begin
                if (!is_aligned(src_ptr)) begin
                    set_err     = 1'b1;
                    ev_n.src_err = 1'b1;
                    st_n        = CH_OFF;
                    ph_n        = PH_IDLE;
                end else if (fetch_ack) begin
                    cur_n = rsp_desc;
                    ph_n  = PH_XFER;
                end
            end
            PH_XFER: begin
                if (xfer_done) begin
                    ev_n.done     = 1'b1;
                    ev_n.src_done = cur_q.irq;
                    if (reg_mode || cur_q.op == OP_STOP) begin
                        clr_en = 1'b1;
                        st_n   = CH_OFF;
                        ph_n   = PH_IDLE;
                    end else if (cur_q.op == OP_HALT) begin
                        st_n       = CH_HOLD;
                        ev_n.pause = 1'b1;
                        ph_n       = PH_IDLE;
                    end else if (cur_q.linked) begin
                        ph_n = PH_LINK;
                    end else begin
                        step_lin = 1'b1;
                        ph_n     = PH_SRC;
                    end
                end
            end
            PH_LINK: begin
                if (fetch_ack) begin
                    set_link = 1'b1;
                    ph_n     = PH_SRC;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            state_q <= CH_OFF;
            cur_q   <= '0;
            ev_q    <= '0;
        end else begin
            phase_q <= ph_n;
            state_q <= st_n;
            cur_q   <= cur_n;
            ev_q    <= ev_n;
        end
    end

    always_comb begin
        fetch_req  = 1'b0;
        fetch_kind = FK_SRC;
        fetch_addr = src_ptr;
        case (phase_q)
            PH_DST: begin
                fetch_req  = is_aligned(dst_ptr);
                fetch_kind = FK_DST;
                fetch_addr = dst_ptr;
            end
            PH_SRC: begin
                fetch_req  = is_aligned(src_ptr);
            end
            PH_LINK: begin
                fetch_req  = 1'b1;
                fetch_kind = FK_LINK;
                fetch_addr = next_linear(src_ptr);
            end
            default: ;
        endcase
    end

    assign xfer_go = (phase_q == PH_XFER);
    assign state   = state_q;
    assign ev      = ev_q;

    // R6
    src_done_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.src_done |-> ev_q.done);

    // R5
    pause_state_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.pause |-> (state_q == CH_HOLD));

    // R5
    stop_off_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_XFER && xfer_done && cur_q.op == OP_STOP) |=> (state_q == CH_OFF));

    // R10
    fetch_align_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_kind != FK_LINK) |-> is_aligned(fetch_addr));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && phase_q == PH_XFER && !xfer_done) |=> (phase_q == PH_XFER));

    // R11
    reg_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && ctl_en && reg_mode && state_q == CH_OFF) |=> !fetch_req);
endmodule

// File: rtl/dcs_top.sv
module dcs_top
    import dcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic        ctl_en,
    input  logic        ctl_cont,
    input  logic        ctl_from_start,
    input  logic        reg_mode,
    input  logic [1:0]  reg_op,
    input  logic        reg_linked,
    input  logic        reg_irq,
    input  logic [48:0] src_start,
    input  logic [48:0] dst_start,
    output logic        fetch_req,
    output logic [1:0]  fetch_kind,
    output logic [48:0] fetch_addr,
    input  logic        fetch_ack,
    input  logic [1:0]  rsp_op,
    input  logic        rsp_linked,
    input  logic        rsp_irq,
    input  logic [48:0] rsp_link,
    output logic        xfer_go,
    input  logic        xfer_done,
    output logic [1:0]  ch_status,
    output logic        en_bit,
    output logic        cont_bit,
    output logic [48:0] src_ptr,
    output logic [48:0] dst_ptr,
    output logic        ev_xfer_done,
    output logic        ev_src_done,
    output logic        ev_pause,
    output logic        ev_src_rd_err,
    output logic        ev_dst_rd_err
);
    logic accept, clr_en, clr_cont, set_err;
    logic load_start, step_lin, set_link;
    logic err_q;
    logic [1:0] state;
    addr_t src_q, dst_q;
    desc_ctl_t reg_desc, rsp_desc;
    ev_t ev;

    assign reg_desc = '{op: reg_op, linked: reg_linked, irq: reg_irq};
    assign rsp_desc = '{op: rsp_op, linked: rsp_linked, irq: rsp_irq};

    dcs_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .ctl_wr         (ctl_wr),
        .ctl_en         (ctl_en),
        .ctl_cont       (ctl_cont),
        .ctl_from_start (ctl_from_start),
        .reg_mode       (reg_mode),
        .reg_desc       (reg_desc),
        .src_ptr        (src_q),
        .dst_ptr        (dst_q),
        .fetch_ack      (fetch_ack),
        .rsp_desc       (rsp_desc),
        .xfer_done      (xfer_done),
        .accept         (accept),
        .clr_en         (clr_en),
        .clr_cont       (clr_cont),
        .set_err        (set_err),
        .load_start     (load_start),
        .step_lin       (step_lin),
        .set_link       (set_link),
        .state          (state),
        .fetch_req      (fetch_req),
        .fetch_kind     (fetch_kind),
        .fetch_addr     (fetch_addr),
        .xfer_go        (xfer_go),
        .ev             (ev)
    );

    dcs_ptr_unit u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load_start (load_start),
        .step_lin   (step_lin),
        .set_link   (set_link),
        .src_start  (src_start),
        .dst_start  (dst_start),
        .link_val   (rsp_link),
        .src_ptr    (src_q),
        .dst_ptr    (dst_q)
    );

    dcs_ctl_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .wr_en    (ctl_en),
        .wr_cont  (ctl_cont),
        .clr_en   (clr_en),
        .clr_cont (clr_cont),
        .set_err  (set_err),
        .state    (state),
        .en_q     (en_bit),
        .cont_q   (cont_bit),
        .err_q    (err_q),
        .status   (ch_status)
    );

    assign src_ptr       = src_q;
    assign dst_ptr       = dst_q;
    assign ev_xfer_done  = ev.done;
    assign ev_src_done   = ev.src_done;
    assign ev_pause      = ev.pause;
    assign ev_src_rd_err = ev.src_err;
    assign ev_dst_rd_err = ev.dst_err;

    // R10
    fault_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (ch_status == STATUS_FAULT) && (ev_src_rd_err || ev_dst_rd_err));
endmodule

// File: tb/tb_dcs_top.sv
`timescale 1ns/1ps
module tb_dcs_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, ctl_en = 0, ctl_cont = 0, ctl_from_start = 0;
    logic reg_mode = 0, reg_linked = 0, reg_irq = 0;
    logic [1:0] reg_op = 0;
    logic [48:0] src_start = 0, dst_start = 0;
    logic fetch_req, fetch_ack = 0;
    logic [1:0] fetch_kind;
    logic [48:0] fetch_addr;
    logic [1:0] rsp_op = 0;
    logic rsp_linked = 0, rsp_irq = 0;
    logic [48:0] rsp_link = 0;
    logic xfer_go, xfer_done = 0;
    logic [1:0] ch_status;
    logic en_bit, cont_bit;
    logic [48:0] src_ptr, dst_ptr;
    logic ev_xfer_done, ev_src_done, ev_pause, ev_src_rd_err, ev_dst_rd_err;

    always #2.5 clk = ~clk;

    dcs_top dut (.*);

    logic [1:0]  op_m  [16];
    logic        lnk_f [16];
    logic        irq_m [16];
    logic [48:0] lnk_m [16];

    logic [48:0] lg_addr [32];
    logic [1:0]  lg_kind [32];
    int nlog = 0;
    int n_done = 0, n_sdone = 0, n_pause = 0, n_serr = 0, n_derr = 0, n_trio = 0;
    int nchk = 0, nfail = 0, cyc = 0;
    logic collide = 0, coll_fired = 0;

    always @(negedge clk) begin
        if (coll_fired) begin
            ctl_wr = 0;
            coll_fired = 0;
        end
        if (fetch_req && !fetch_ack) begin
            fetch_ack = 1;
            if (nlog < 32) begin
                lg_addr[nlog] = fetch_addr;
                lg_kind[nlog] = fetch_kind;
                nlog++;
            end
            rsp_op     = op_m[fetch_addr[7:4]];
            rsp_linked = lnk_f[fetch_addr[7:4]];
            rsp_irq    = irq_m[fetch_addr[7:4]];
            rsp_link   = lnk_m[fetch_addr[7:4]];
        end else begin
            fetch_ack = 0;
        end
        if (xfer_go && !xfer_done) begin
            xfer_done = 1;
            if (collide) begin
                ctl_wr = 1; ctl_en = 0; ctl_cont = 1; ctl_from_start = 0;
                collide = 0;
                coll_fired = 1;
            end
        end else begin
            xfer_done = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (ev_xfer_done) n_done++;
            if (ev_src_done) n_sdone++;
            if (ev_pause) n_pause++;
            if (ev_src_rd_err) n_serr++;
            if (ev_dst_rd_err) n_derr++;
            if (ev_xfer_done && ev_src_done && ev_pause) n_trio++;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nlog = 0; n_done = 0; n_sdone = 0; n_pause = 0; n_serr = 0; n_derr = 0; n_trio = 0;
    endtask

    task automatic ctl_write(input logic en, input logic cont, input logic fs);
        @(negedge clk);
        ctl_wr = 1; ctl_en = en; ctl_cont = cont; ctl_from_start = fs;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic wait_settle();
        for (int i = 0; i < 2000; i++) begin
            if (ch_status != 2'd1 && !fetch_req && !xfer_go) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_log(input string req, input int i, input logic [1:0] k, input logic [48:0] a);
        chk(req, {62'd0, lg_kind[i]}, {62'd0, k});
        chk(req, {15'd0, lg_addr[i]}, {15'd0, a});
    endtask

    task automatic t_reset();
        chk("R1 status", ch_status, 0);
        chk("R1 en", en_bit, 0);
        chk("R1 cont", cont_bit, 0);
        chk("R1 idle", {fetch_req, xfer_go, ev_xfer_done, ev_pause, ev_src_rd_err}, 0);
    endtask

    task automatic t_linear();
        clear_log();
        src_start = 49'h1000; dst_start = 49'h2000;
        ctl_write(1, 0, 0);
        chk("R2 running", ch_status, 1);
        wait_settle();
        chk("R2 count", nlog, 4);
        chk_log("R2 dst first", 0, 2'd1, 49'h2000);
        chk_log("R2 src start", 1, 2'd0, 49'h1000);
        chk_log("R3 step", 2, 2'd0, 49'h1010);
        chk_log("R3 step2", 3, 2'd0, 49'h1020);
        chk("R6 done", n_done, 3);
        chk("R6 src_done", n_sdone, 2);
        chk("R5 stop status", ch_status, 0);
        chk("R5 stop en", en_bit, 0);
    endtask

    task automatic t_linked_resume();
        clear_log();
        src_start = 49'h1040;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R4 count", nlog, 4);
        chk_log("R4 link fetch", 2, 2'd2, 49'h1050);
        chk_log("R4 follow", 3, 2'd0, 49'h1080);
        chk("R5 paused", ch_status, 2);
        chk("R5 pause ev", n_pause, 1);
        chk("R5 en kept", en_bit, 1);
        ctl_write(1, 1, 0);
        chk("R7 cont cleared", cont_bit, 0);
        wait_settle();
        chk("R7 count", nlog, 5);
        chk_log("R7 next", 4, 2'd0, 49'h1090);
        chk("R7 end", ch_status, 0);
    endtask

    task automatic t_from_start();
        clear_log();
        src_start = 49'h10A0;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R8 paused", ch_status, 2);
        ctl_write(1, 0, 0);
        repeat (4) @(negedge clk);
        chk("R9 stay paused", ch_status, 2);
        chk("R9 no fetch", nlog, 2);
        ctl_write(1, 1, 1);
        wait_settle();
        chk("R8 count", nlog, 4);
        chk_log("R8 dst again", 2, 2'd1, 49'h2000);
        chk_log("R8 src again", 3, 2'd0, 49'h10A0);
        chk("R8 paused again", ch_status, 2);
        ctl_write(0, 1, 0);
        repeat (2) @(negedge clk);
        chk("R9 leave", ch_status, 0);
        chk("R9 en", en_bit, 0);
    endtask

    task automatic t_misalign();
        clear_log();
        src_start = 49'h1008; dst_start = 49'h2000;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R10 src status", ch_status, 3);
        chk("R10 src ev", n_serr, 1);
        chk("R10 no src fetch", nlog, 1);
        clear_log();
        src_start = 49'h1020; dst_start = 49'h2004;
        ctl_write(1, 0, 0);
        chk("R10 cleared", ch_status, 1);
        wait_settle();
        chk("R10 dst status", ch_status, 3);
        chk("R10 dst ev", n_derr, 1);
        chk("R10 no dst fetch", nlog, 0);
        clear_log();
        dst_start = 49'h2000;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R10 recover", ch_status, 0);
        chk("R10 recover done", n_done, 1);
    endtask

    task automatic t_regmode();
        clear_log();
        reg_mode = 1; reg_irq = 1; reg_op = 0; reg_linked = 0;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R11 no fetch", nlog, 0);
        chk("R11 done", n_done, 1);
        chk("R11 src_done", n_sdone, 1);
        chk("R11 status", ch_status, 0);
        chk("R11 en", en_bit, 0);
        reg_mode = 0;
    endtask

    task automatic t_collide();
        clear_log();
        src_start = 49'h1030;
        collide = 1;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R12 paused", ch_status, 2);
        chk("R12 en", en_bit, 1);
        chk("R12 cont", cont_bit, 0);
        chk("R6 trio", n_trio, 1);
        ctl_write(0, 1, 0);
        repeat (2) @(negedge clk);
        chk("R9 off", ch_status, 0);
    endtask

    task automatic t_wrap();
        clear_log();
        src_start = 49'h1_FFFF_FFFF_FFF0;
        ctl_write(1, 0, 0);
        wait_settle();
        chk("R3 wrap count", nlog, 5);
        chk_log("R3 wrap top", 1, 2'd0, 49'h1_FFFF_FFFF_FFF0);
        chk_log("R3 wrap zero", 2, 2'd0, 49'h0);
        chk("R3 wrap done", n_done, 4);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            op_m[i] = 0; lnk_f[i] = 0; irq_m[i] = 0; lnk_m[i] = 0;
        end
        irq_m[1] = 1;
        op_m[2] = 2; irq_m[2] = 1;
        op_m[3] = 1; irq_m[3] = 1;
        lnk_f[4] = 1; lnk_m[5] = 49'h1080;
        op_m[8] = 1;
        op_m[9] = 2; irq_m[9] = 1;
        op_m[10] = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_linked_resume();
        t_from_start();
        t_misalign();
        t_regmode();
        t_collide();
        t_wrap();
        finish_run();
    end
endmodule